// File: doc/BRIEF.md
# In-band XOFF/XON Transmit Inserter

This block sits in front of a serial transmitter and asks the link partner to pause or resume sending, based on how full the local receive buffer is. It watches the receive FIFO fill level against two programmable thresholds. When the level climbs above the high threshold it queues one "stop" character. When the level later drops below the low threshold it queues one "go" character. The band between the two thresholds gives hysteresis.

The injected character goes to the transmitter through a valid/ready handshake. It wins over ordinary transmit FIFO data, so it is sent in the first slot after the character now in the shifter completes. A 2-bit mode field chooses which of two programmed stop/go character pairs is used, or turns the feature off. The feature also needs the enhanced-feature enable to be set, and it is forced off while 9-bit character mode is active.

Top module: `fc_tx_inject`

## Requirements
- R1: After reset no flow character is pending. `tx_valid`/`tx_data` follow `fifo_valid`/`fifo_data`, and `fifo_ready` equals `tx_ready`.
- R2: With mode 2'b10, the stop character is `xoff_a` and the go character is `xon_a`.
- R3: With mode 2'b01, the stop character is `xoff_b` and the go character is `xon_b`.
- R4: Mode 2'b00 and the reserved mode 2'b11 both disable injection. No flow character is presented in the cycle after such a mode is seen.
- R5: When `enh_en` is 0 the mode field is ignored and nothing is injected.
- R6: When `nine_bit` is 1 nothing is injected.
- R7: A stop character is presented in the cycle after `rx_level > thr_hi` is sampled. A level equal to `thr_hi` does not trigger it.
- R8: After a stop character has been sent, a go character is presented in the cycle after `rx_level < thr_lo` is sampled. A level equal to `thr_lo` does not trigger it.
- R9: Each threshold crossing produces exactly one character. The level hovering at or beyond a threshold produces no repeats.
- R10: If the level falls below `thr_lo` before a pending stop character is accepted, the pending request is withdrawn. Neither the stop nor a go character is sent.
- R11: While a flow character is pending it drives `tx_data`, and `fifo_ready` is held low.
- R12: Disabling the feature (through mode, `enh_en` or `nine_bit`) clears any pending request.
- R13: A pending flow character holds its value on `tx_data` until `tx_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| thr_hi | input | LVL_W | Upper threshold (stop when exceeded) |
| thr_lo | input | LVL_W | Lower threshold (go when undershot) |
| tx_mode | input | 2 | Flow mode: 00 off, 01 second pair, 10 first pair, 11 off |
| enh_en | input | 1 | Enhanced-feature enable |
| nine_bit | input | 1 | 9-bit character mode active |
| xon_a | input | CHAR_W | Go character of the first pair |
| xoff_a | input | CHAR_W | Stop character of the first pair |
| xon_b | input | CHAR_W | Go character of the second pair |
| xoff_b | input | CHAR_W | Stop character of the second pair |
| fifo_valid | input | 1 | Normal transmit FIFO has data |
| fifo_data | input | CHAR_W | Normal transmit FIFO head |
| fifo_ready | output | 1 | FIFO head consumed this cycle |
| tx_valid | output | 1 | Character offered to the shifter |
| tx_data | output | CHAR_W | Character offered to the shifter |
| tx_ready | input | 1 | Shifter accepts a character |

## Verification
The bench pushes the hysteresis with levels equal to each threshold, where a design using >= or <= would send early, and with repeated excursions above the upper threshold, where a design without the remote-state bit would send a second stop. It blocks the shifter and pulls the level back below the low threshold while a stop is pending. A design that does not withdraw the request would send a stray stop followed by a go. It also disables the feature with a request still pending and then re-enables it, which catches a request left over from before. Pair selection is checked in both active modes and in the reserved mode, so swapped or mis-decoded pairs show up as wrong bytes in the scoreboard.

// File: rtl/fc_pkg.sv
// Shared definitions for the in-band flow character inserter.
// Assumes the mode field is two bits wide; the encodings select the pair.
package fc_pkg;
    typedef enum logic [1:0] {
        FC_OFF    = 2'b00,
        FC_PAIR_B = 2'b01,
        FC_PAIR_A = 2'b10,
        FC_RSVD   = 2'b11
    } fc_mode_e;

    // True when the mode encoding requests injection with some pair.
    function automatic logic mode_is_active(input fc_mode_e m);
        return (m == FC_PAIR_A) || (m == FC_PAIR_B);
    endfunction
endpackage

// File: rtl/fc_mode_dec.sv
// Decodes the enable conditions and picks the active stop/go character pair.
// Assumes the reserved mode behaves exactly like the off mode.
module fc_mode_dec
    import fc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic [1:0]        tx_mode,
    input  logic              enh_en,
    input  logic              nine_bit,
    input  logic [CHAR_W-1:0] xon_a,
    input  logic [CHAR_W-1:0] xoff_a,
    input  logic [CHAR_W-1:0] xon_b,
    input  logic [CHAR_W-1:0] xoff_b,
    output logic              active,
    output logic [CHAR_W-1:0] sel_xon,
    output logic [CHAR_W-1:0] sel_xoff
);
    fc_mode_e mode;

    // Gate the feature by enhanced mode and character size.
    always_comb begin
        mode   = fc_mode_e'(tx_mode);
        active = enh_en && !nine_bit && mode_is_active(mode);
    end

    // Choose the pair; the first pair is only used for its own encoding.
    always_comb begin
        if (mode == FC_PAIR_A) begin
            sel_xon  = xon_a;
            sel_xoff = xoff_a;
        end else begin
            sel_xon  = xon_b;
            sel_xoff = xoff_b;
        end
    end
endmodule

// File: rtl/fc_hyst.sv
// Hysteresis tracker: decides whether the partner should currently be stopped.
// Assumes thr_lo <= thr_hi; levels strictly beyond a threshold act.
module fc_hyst #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             want_stop
);
    logic above_hi;
    logic below_lo;

    // Strict comparisons against both thresholds.
    always_comb begin
        above_hi = rx_level > thr_hi;
        below_lo = rx_level < thr_lo;
    end

    // Desired partner state, held between the thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            want_stop <= 1'b0;
        end else if (above_hi) begin
            want_stop <= 1'b1;
        end else if (below_lo) begin
            want_stop <= 1'b0;
        end
    end
endmodule

// File: rtl/fc_track.sv
// Remembers what the partner was last told and raises a request on mismatch.
// A request withdrawn by the tracker before acceptance is simply dropped.
module fc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic want_stop,
    input  logic accept,
    output logic pend,
    output logic pend_is_stop
);
    logic told_stop;

    // Partner state as last signalled on the line.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            told_stop <= 1'b0;
        end else if (accept) begin
            told_stop <= ~told_stop;
        end
    end

    // A request exists whenever the wish differs from what was sent.
    always_comb begin
        pend         = want_stop ^ told_stop;
        pend_is_stop = want_stop & ~told_stop;
    end
endmodule

// File: rtl/fc_tx_arb.sv
// Gives a pending flow character precedence over the transmit FIFO head.
// Assumes tx_ready means the shifter takes tx_data in this cycle.
module fc_tx_arb #(
    parameter int CHAR_W = 8
) (
    input  logic              flow_valid,
    input  logic [CHAR_W-1:0] flow_char,
    input  logic              fifo_valid,
    input  logic [CHAR_W-1:0] fifo_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              fifo_ready,
    output logic              flow_accept
);
    // Select the source and route the handshake back to it.
    always_comb begin
        tx_valid    = flow_valid | fifo_valid;
        tx_data     = flow_valid ? flow_char : fifo_data;
        fifo_ready  = tx_ready & ~flow_valid;
        flow_accept = tx_ready & flow_valid;
    end
endmodule

// File: rtl/fc_tx_inject.sv
// Top of the in-band flow character inserter: threshold hysteresis,
// one-shot request tracking, pair selection and transmit priority.
module fc_tx_inject #(
    parameter int LVL_W  = 8,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  thr_hi,
    input  logic [LVL_W-1:0]  thr_lo,
    input  logic [1:0]        tx_mode,
    input  logic              enh_en,
    input  logic              nine_bit,
    input  logic [CHAR_W-1:0] xon_a,
    input  logic [CHAR_W-1:0] xoff_a,
    input  logic [CHAR_W-1:0] xon_b,
    input  logic [CHAR_W-1:0] xoff_b,
    input  logic              fifo_valid,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready
);
    logic              active;
    logic [CHAR_W-1:0] sel_xon;
    logic [CHAR_W-1:0] sel_xoff;
    logic              want_stop;
    logic              flow_valid;
    logic              pend_is_stop;
    logic              flow_accept;
    logic [CHAR_W-1:0] flow_char;

    fc_mode_dec #(.CHAR_W(CHAR_W)) u_dec (
        .tx_mode (tx_mode),
        .enh_en  (enh_en),
        .nine_bit(nine_bit),
        .xon_a   (xon_a),
        .xoff_a  (xoff_a),
        .xon_b   (xon_b),
        .xoff_b  (xoff_b),
        .active  (active),
        .sel_xon (sel_xon),
        .sel_xoff(sel_xoff)
    );

    fc_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .rx_level (rx_level),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .want_stop(want_stop)
    );

    fc_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .want_stop   (want_stop),
        .accept      (flow_accept),
        .pend        (flow_valid),
        .pend_is_stop(pend_is_stop)
    );

    // Pick the character that matches the pending direction.
    always_comb flow_char = pend_is_stop ? sel_xoff : sel_xon;

    fc_tx_arb #(.CHAR_W(CHAR_W)) u_arb (
        .flow_valid (flow_valid),
        .flow_char  (flow_char),
        .fifo_valid (fifo_valid),
        .fifo_data  (fifo_data),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .fifo_ready (fifo_ready),
        .flow_accept(flow_accept)
    );
endmodule

// File: rtl/fc_tx_inject_chk.sv
// Checker for fc_tx_inject, bound to every instance of the top.
module fc_tx_inject_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        tx_mode,
    input logic              enh_en,
    input logic              nine_bit,
    input logic [CHAR_W-1:0] xon_a,
    input logic [CHAR_W-1:0] xoff_a,
    input logic [CHAR_W-1:0] xon_b,
    input logic [CHAR_W-1:0] xoff_b,
    input logic              fifo_ready,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              flow_valid
);
    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'b00 || tx_mode == 2'b11) |=> !flow_valid); // R4
    AST_ENH_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> !flow_valid); // R5
    AST_NINE_BIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nine_bit |=> !flow_valid); // R6
    AST_PAIR_A_CHARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_valid && tx_mode == 2'b10) |-> (tx_data == xon_a || tx_data == xoff_a)); // R2
    AST_PAIR_B_CHARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_valid && tx_mode == 2'b01) |-> (tx_data == xon_b || tx_data == xoff_b)); // R3
    AST_FLOW_BLOCKS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        flow_valid |-> (tx_valid && !fifo_ready)); // R11
    AST_HELD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flow_valid && !tx_ready) && flow_valid && $stable(tx_mode)
         && $stable(xoff_a) && $stable(xon_a) && $stable(xoff_b) && $stable(xon_b))
        |-> $stable(tx_data)); // R13
endmodule

bind fc_tx_inject fc_tx_inject_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_mode   (tx_mode),
    .enh_en    (enh_en),
    .nine_bit  (nine_bit),
    .xon_a     (xon_a),
    .xoff_a    (xoff_a),
    .xon_b     (xon_b),
    .xoff_b    (xoff_b),
    .fifo_ready(fifo_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .flow_valid(flow_valid)
);

// File: tb/fc_tx_inject_bench.sv
`timescale 1ns/1ps
module fc_tx_inject_bench;
    localparam int LVL_W  = 8;
    localparam int CHAR_W = 8;
    localparam logic [7:0] XON_A = 8'h11, XOFF_A = 8'h13;
    localparam logic [7:0] XON_B = 8'h51, XOFF_B = 8'h53;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic [LVL_W-1:0]  thr_hi = 8'd100;
    logic [LVL_W-1:0]  thr_lo = 8'd20;
    logic [1:0]        tx_mode = 2'b10;
    logic              enh_en = 1'b1;
    logic              nine_bit = 1'b0;
    logic              fifo_valid = 1'b0;
    logic [CHAR_W-1:0] fifo_data = '0;
    logic              fifo_ready;
    logic              tx_valid;
    logic [CHAR_W-1:0] tx_data;
    logic              tx_ready = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    fc_tx_inject #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_fc_tx_inject (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_hi(thr_hi),
        .thr_lo(thr_lo), .tx_mode(tx_mode), .enh_en(enh_en), .nine_bit(nine_bit),
        .xon_a(XON_A), .xoff_a(XOFF_A), .xon_b(XON_B), .xoff_b(XOFF_B),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every accepted character must match the scoreboard front.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected character", tx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(tx_data == e, "R2/R3/R7/R8 sent character", tx_data, e);
            end
        end
    end

    task automatic drive_level(input int v);
        @(posedge clk); #1;
        rx_level = v[LVL_W-1:0];
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drained(input string tag);
        idle(3);
        @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        @(posedge clk); #1;
        rst_n = 1'b1;
        fifo_valid = 1'b1; fifo_data = 8'h3C; tx_ready = 1'b0;
        @(negedge clk);
        check(tx_valid && tx_data == 8'h3C, "R1 fifo passes after reset", tx_data, 8'h3C);
        check(fifo_ready == 1'b0, "R1 fifo_ready follows tx_ready", fifo_ready, 0);
        @(posedge clk); #1;
        fifo_valid = 1'b0; tx_ready = 1'b1; rx_level = 8'd50;
        drained("R1 nothing injected at mid level");

        // First pair, thresholds and hysteresis
        drive_level(100);
        drained("R7 level equal to thr_hi sends nothing");
        exp_q.push_back(XOFF_A);
        drive_level(101);
        drained("R7 R2 stop sent above thr_hi");
        drive_level(100); drive_level(99); drive_level(105); drive_level(130);
        drained("R9 no repeat while hovering high");
        drive_level(20);
        drained("R8 level equal to thr_lo sends nothing");
        exp_q.push_back(XON_A);
        drive_level(19);
        drained("R8 R2 go sent below thr_lo");
        drive_level(10); drive_level(25); drive_level(5);
        drained("R9 no repeat while hovering low");

        // Second pair
        @(posedge clk); #1; tx_mode = 2'b01;
        exp_q.push_back(XOFF_B);
        drive_level(120);
        drained("R3 second pair stop");
        exp_q.push_back(XON_B);
        drive_level(5);
        drained("R3 second pair go");

        // Disabled configurations
        @(posedge clk); #1; tx_mode = 2'b00;
        drive_level(120);
        drained("R4 mode off sends nothing");
        drive_level(5);
        @(posedge clk); #1; tx_mode = 2'b11;
        drive_level(120);
        drained("R4 reserved mode sends nothing");
        drive_level(5);
        @(posedge clk); #1; tx_mode = 2'b10; enh_en = 1'b0;
        drive_level(120);
        drained("R5 enhanced off sends nothing");
        drive_level(5);
        @(posedge clk); #1; enh_en = 1'b1; nine_bit = 1'b1;
        drive_level(120);
        drained("R6 nine-bit mode sends nothing");
        drive_level(5);
        @(posedge clk); #1; nine_bit = 1'b0;
        idle(2);

        // Priority, hold and withdrawal
        @(posedge clk); #1;
        tx_ready = 1'b0; fifo_valid = 1'b1; fifo_data = 8'hA5; rx_level = 8'd120;
        idle(3);
        @(negedge clk);
        check(tx_valid && tx_data == XOFF_A, "R11 stop ahead of fifo data", tx_data, XOFF_A);
        check(fifo_ready == 1'b0, "R11 fifo held back", fifo_ready, 0);
        idle(2);
        @(negedge clk);
        check(tx_data == XOFF_A, "R13 stop held while blocked", tx_data, XOFF_A);
        @(posedge clk); #1;
        fifo_valid = 1'b0; rx_level = 8'd5;
        idle(2);
        @(negedge clk);
        check(tx_valid == 1'b0, "R10 pending stop withdrawn", tx_valid, 0);
        @(posedge clk); #1; tx_ready = 1'b1;
        drained("R10 nothing sent after withdrawal");

        // Disable clears a pending request
        @(posedge clk); #1; tx_ready = 1'b0; rx_level = 8'd120;
        idle(3);
        @(negedge clk);
        check(tx_valid == 1'b1, "R12 request pending before disable", tx_valid, 1);
        @(posedge clk); #1; enh_en = 1'b0;
        idle(2);
        @(negedge clk);
        check(tx_valid == 1'b0, "R12 request cleared by disable", tx_valid, 0);
        @(posedge clk); #1; rx_level = 8'd50; enh_en = 1'b1; tx_ready = 1'b1;
        drained("R12 no stale request after re-enable");

        summary();
        $finish;
    end
endmodule